// File: doc/BRIEF.md
# Two-Core Cache Region Split Tuner

This block decides how sixteen equal slices of a shared cache are divided between two cores, and it adjusts that division at run time by local search. It keeps a committed split, where core 0 owns the low `quota0` slices and core 1 owns the rest. While enabled, it repeats a search sequence over consecutive measurement intervals. Each interval is delimited by a pulse on `epoch_tick`. In the first interval the committed split is applied. In the next interval core 0 is given one slice fewer, and in the interval after that it is given one slice more. At the end of the sequence, the split with the fewest combined misses becomes the new committed split, and a new sequence begins at once.

Miss events arrive as single-cycle strobes, one per core. These strobes feed two saturating counters that restart at every interval boundary. The outputs are the two applied quotas and a slice ownership mask. A page allocator or set-index remapper elsewhere in the chip uses these outputs to steer each core's fills. When `run` is lowered, the interval in progress is allowed to complete. The block then parks on its committed split and raises `done`.

Top module: `cache_split_tuner`

## Requirements
- R1: After reset, `quota0` = 8, `quota1` = 8, `region_mask` = 16'h00FF and `done` = 0. The block is idle and waits for an `epoch_tick` with `run` high.
- R2: While running, the applied split follows a fixed order at each tick. The committed split P is applied first, then P-1 for core 0, then P+1 for core 0, and then the newly chosen split.
- R3: The metric for an interval is the number of cycles with `miss0` high plus the number of cycles with `miss1` high. The tick cycle itself belongs to the next interval. Each count saturates at 2^CNT_W-1.
- R4: At the end of a sequence, the candidate with the strictly lowest metric is committed. On a tie, the committed split is kept first, and P-1 is preferred over P+1.
- R5: A core never holds fewer than 1 slice. When P = 1, the P-1 trial is skipped and the P+1 trial is applied directly after the committed split. When P = 15, the P+1 trial is skipped and the decision is taken at the end of the P-1 trial.
- R6: `quota1` = 16 - `quota0`. Bit i of `region_mask` is 1 (the slice belongs to core 0) exactly when i < `quota0`.
- R7: `quota0`, `quota1` and `region_mask` change only at the clock edge where `epoch_tick` is high.
- R8: If `run` is low at a tick that ends a trial, the block goes idle and sets `done` = 1. When the sequence is not yet complete, the unfinished sequence is discarded and the committed split is applied. When that tick completes the sequence, the decision is committed first and then applied.
- R9: While idle, a tick with `run` high clears `done` and starts a new sequence from the committed split. A tick with `run` low leaves everything unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High to keep tuning; low requests a stop at the next interval end |
| epoch_tick | input | 1 | One-cycle pulse marking an interval boundary |
| miss0 | input | 1 | Miss strobe from core 0 |
| miss1 | input | 1 | Miss strobe from core 1 |
| quota0 | output | 5 | Slices applied to core 0 |
| quota1 | output | 5 | Slices applied to core 1 |
| region_mask | output | 16 | Per-slice owner, 1 = core 0 |
| done | output | 1 | High while stopped after a run |

## Verification
Every result of this block is registered at the edge where `epoch_tick` is sampled high. The next quota, the mask, the metric snapshot and `done` all become visible one cycle after the tick is driven. Miss counts contribute only to the decision that becomes visible at the last tick of a sequence. The bench therefore drives each interval on falling edges and places a single tick at its end. It samples every output on the falling edge that follows the tick's rising edge. In the middle of each interval it also confirms that the outputs have not moved since the previous boundary.

// File: rtl/cache_split_tuner.sv
module cache_split_tuner #(
  parameter int REGIONS = 16,
  parameter int CNT_W   = 24,
  parameter int MIN_Q   = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             run,
  input  logic                             epoch_tick,
  input  logic                             miss0,
  input  logic                             miss1,
  output logic [$clog2(REGIONS+1)-1:0]     quota0,
  output logic [$clog2(REGIONS+1)-1:0]     quota1,
  output logic [REGIONS-1:0]               region_mask,
  output logic                             done
);
  localparam int QW   = $clog2(REGIONS+1);
  localparam int SW   = CNT_W + 1;
  localparam int MAXQ = REGIONS - MIN_Q;
  localparam logic [1:0] PH_IDLE = 2'd0, PH_CUR = 2'd1, PH_LO = 2'd2, PH_HI = 2'd3;

  logic [1:0]       phase;
  logic [QW-1:0]    cur_p0, app_p0, best_p0;
  logic [CNT_W-1:0] cnt0, cnt1;
  logic [SW-1:0]    epoch_sum, sum_cur, sum_lo, cmp_l, keep_v;
  logic             lo_ok, cmp_lv, cmp_hv, lo_legal, hi_legal;

  assign epoch_sum = SW'(cnt0) + SW'(cnt1);
  assign lo_legal  = cur_p0 > QW'(MIN_Q);
  assign hi_legal  = cur_p0 < QW'(MAXQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt0 <= '0;
      cnt1 <= '0;
    end else begin
      if (epoch_tick)              cnt0 <= CNT_W'(miss0);
      else if (miss0 && ~&cnt0)    cnt0 <= cnt0 + CNT_W'(1);
      if (epoch_tick)              cnt1 <= CNT_W'(miss1);
      else if (miss1 && ~&cnt1)    cnt1 <= cnt1 + CNT_W'(1);
    end
  end

  always_comb begin
    cmp_l   = (phase == PH_HI) ? sum_lo : epoch_sum;
    cmp_lv  = (phase == PH_HI) ? lo_ok  : 1'b1;
    cmp_hv  = (phase == PH_HI);
    keep_v  = sum_cur;
    best_p0 = cur_p0;
    if (cmp_lv && cmp_l < keep_v) begin
      keep_v  = cmp_l;
      best_p0 = cur_p0 - QW'(1);
    end
    if (cmp_hv && epoch_sum < keep_v)
      best_p0 = cur_p0 + QW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cur_p0  <= QW'(REGIONS / 2);
      app_p0  <= QW'(REGIONS / 2);
      sum_cur <= '0;
      sum_lo  <= '0;
      lo_ok   <= 1'b0;
      done    <= 1'b0;
    end else if (epoch_tick) begin
      case (phase)
        PH_IDLE: if (run) begin
          phase  <= PH_CUR;
          app_p0 <= cur_p0;
          done   <= 1'b0;
        end
        PH_CUR: begin
          sum_cur <= epoch_sum;
          if (!run) begin
            phase  <= PH_IDLE;
            app_p0 <= cur_p0;
            done   <= 1'b1;
          end else if (lo_legal) begin
            phase  <= PH_LO;
            app_p0 <= cur_p0 - QW'(1);
            lo_ok  <= 1'b1;
          end else begin
            phase  <= PH_HI;
            app_p0 <= cur_p0 + QW'(1);
            lo_ok  <= 1'b0;
          end
        end
        PH_LO: begin
          sum_lo <= epoch_sum;
          if (hi_legal) begin
            if (!run) begin
              phase  <= PH_IDLE;
              app_p0 <= cur_p0;
              done   <= 1'b1;
            end else begin
              phase  <= PH_HI;
              app_p0 <= cur_p0 + QW'(1);
            end
          end else begin
            cur_p0 <= best_p0;
            app_p0 <= best_p0;
            phase  <= run ? PH_CUR : PH_IDLE;
            done   <= !run;
          end
        end
        default: begin
          cur_p0 <= best_p0;
          app_p0 <= best_p0;
          phase  <= run ? PH_CUR : PH_IDLE;
          done   <= !run;
        end
      endcase
    end
  end

  assign quota0 = app_p0;
  assign quota1 = QW'(REGIONS) - app_p0;

  for (genvar i = 0; i < REGIONS; i++) begin : g_mask
    assign region_mask[i] = QW'(i) < app_p0;
  end
endmodule

// File: rtl/split_tuner_chk.sv
module split_tuner_chk #(
  parameter int REGIONS = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         run,
  input logic                         epoch_tick,
  input logic [$clog2(REGIONS+1)-1:0] quota0,
  input logic [$clog2(REGIONS+1)-1:0] quota1,
  input logic [REGIONS-1:0]           region_mask,
  input logic                         done
);
  assert_quota_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(quota0) >= 1 && int'(quota0) <= REGIONS - 1 && int'(quota0) + int'(quota1) == REGIONS));

  assert_mask_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(region_mask) == int'(quota0) && region_mask[0] && !region_mask[REGIONS-1]));

  assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_tick |=> ($stable(quota0) && $stable(region_mask)));

  assert_step_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_tick |=> (int'(quota0) <= int'($past(quota0)) + 2 && int'($past(quota0)) <= int'(quota0) + 2));

  assert_done_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(epoch_tick) && !$past(run)));

  assert_done_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> ($past(epoch_tick) && $past(run)));
endmodule

bind cache_split_tuner split_tuner_chk #(.REGIONS(REGIONS)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .epoch_tick(epoch_tick),
  .quota0(quota0), .quota1(quota1), .region_mask(region_mask), .done(done)
);

// File: tb/sim_cache_split_tuner.sv
module sim_cache_split_tuner;
  localparam int CLK_PERIOD = 10;
  localparam int EP   = 80;
  localparam int NV   = 18;
  // columns: miss0 count, miss1 count, expected quota0 after the tick, requirement
  localparam int VT [NV][4] = '{
    '{10, 10, 7, 2}, '{ 5,  5, 9, 2}, '{15, 15, 7, 4},
    '{ 5,  5, 6, 2}, '{ 5,  5, 8, 2}, '{ 5,  5, 7, 4},
    '{10, 10, 6, 2}, '{10, 10, 8, 2}, '{ 3,  2, 8, 4},
    '{ 6,  6, 7, 2}, '{ 5,  4, 9, 2}, '{ 4,  5, 7, 4},
    '{30, 10, 6, 2}, '{20, 20, 8, 2}, '{25, 25, 7, 4},
    '{70,  0, 6, 3}, '{ 0, 63, 8, 3}, '{64,  0, 7, 3}
  };

  logic clk = 0, rst_n = 0, run = 0, epoch_tick = 0, miss0 = 0, miss1 = 0;
  logic [4:0] quota0, quota1;
  logic [15:0] region_mask;
  logic done;
  int checks = 0, fails = 0, q;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_split_tuner #(.REGIONS(16), .CNT_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .epoch_tick(epoch_tick),
    .miss0(miss0), .miss1(miss1), .quota0(quota0), .quota1(quota1),
    .region_mask(region_mask), .done(done));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_split(input string tag, input int exp_q);
    chk(tag, int'(quota0), exp_q);
    chk("R6 quota1", int'(quota1), 16 - exp_q);
    chk("R6 mask", int'(region_mask), (1 << exp_q) - 1);
  endtask

  // one interval: misses early, a single tick at the end, outputs sampled after it
  task automatic run_epoch(input int m0, input int m1, input bit r);
    int q_before = int'(quota0);
    for (int c = 0; c < EP; c++) begin
      @(negedge clk);
      miss0 = (c < m0); miss1 = (c < m1); run = r; epoch_tick = 0;
      if (c == EP/2) chk("R7 hold", int'(quota0), q_before);
    end
    @(negedge clk);
    miss0 = 0; miss1 = 0; epoch_tick = 1;
    @(negedge clk);
    epoch_tick = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_split("R1 quota0", 8);
    chk("R1 done", int'(done), 0);
    run_epoch(0, 0, 1);                   // R9 start from idle
    chk_split("R9 start", 8);
    for (int i = 0; i < NV; i++) begin    // R2 order, R4 choice, R3 saturation
      run_epoch(VT[i][0], VT[i][1], 1);
      chk($sformatf("R%0d vector %0d", VT[i][3], i), int'(quota0), VT[i][2]);
      chk("R6 mask", int'(region_mask), (1 << VT[i][2]) - 1);
    end
    // R8 stop in mid-sequence discards trials
    run_epoch(10, 10, 1); chk_split("R2 lo trial", 6);
    run_epoch(2, 1, 0);   chk_split("R8 revert", 7); chk("R8 done", int'(done), 1);
    run_epoch(1, 1, 0);   chk_split("R9 idle hold", 7); chk("R9 idle done", int'(done), 1);
    run_epoch(0, 0, 1);   chk_split("R9 restart", 7); chk("R9 done clear", int'(done), 0);
    q = 7;
    while (q > 1) begin
      run_epoch(10, 10, 1); chk_split("R2 walk lo", q - 1);
      run_epoch(2, 2, 1);   chk_split("R2 walk hi", q + 1);
      run_epoch(15, 15, 1); chk_split("R4 walk down", q - 1);
      q--;
    end
    // R5 lower edge: lo trial skipped
    run_epoch(10, 10, 1); chk_split("R5 skip lo", 2);
    run_epoch(15, 15, 1); chk_split("R5 keep 1", 1);
    run_epoch(10, 10, 1); chk_split("R5 skip lo again", 2);
    run_epoch(3, 3, 1);   chk_split("R5 climb", 2);
    q = 2;
    while (q < 15) begin
      run_epoch(10, 10, 1); chk_split("R2 climb lo", q - 1);
      run_epoch(15, 15, 1); chk_split("R2 climb hi", q + 1);
      run_epoch(2, 2, 1);   chk_split("R4 climb", q + 1);
      q++;
    end
    // R5 upper edge: decision taken after the lo trial
    run_epoch(10, 10, 1); chk_split("R5 upper lo", 14);
    run_epoch(15, 15, 1); chk_split("R5 upper keep", 15);
    // R8 stop on the deciding tick commits the result
    run_epoch(10, 10, 1); chk_split("R2 upper lo", 14);
    run_epoch(2, 2, 0);   chk_split("R8 commit", 14); chk("R8 done commit", int'(done), 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule